// File: doc/BRIEF.md
# Hamming-Similarity Top-1 Search Engine

This block keeps a table of fixed-width binary hash rows and, for a query hash, finds the stored row that agrees with it in the most bit positions. Rows are loaded through a plain write port that takes an enable, a row number and a hash. Queries arrive over a valid/ready handshake. The query hash is captured at acceptance. The engine then sweeps the table a batch of rows per cycle through several parallel read lanes. Each lane scores its row as the count of matching bits, and the engine keeps a running winner.

When the sweep ends, the winning row number and its score are presented on a valid/ready result channel. They stay there until the consumer takes them. A busy flag covers the whole interval from acceptance until the result is taken. Writes are meant for idle periods only. A write issued during a sweep has undefined effect on that query.

Top module: `ham_top1_search`

## Requirements
- R1: A row's score is the number of bit positions where the stored hash equals the query (popcount of the XNOR). A row identical to the query scores exactly HASH_W, and its bitwise complement scores 0.
- R2: When several rows share the highest score, the reported row is the one with the smallest index. If every row scores the same, row 0 is reported.
- R3: A query is accepted on a clock edge where query_valid and query_ready are both 1. The hash is captured at that edge, so changes on query_hash afterwards do not alter the result.
- R4: While result_valid is 1 and result_ready is 0, result_valid, top1_row and top1_score hold their values. On the edge where result_ready is 1, the result is consumed and result_valid is 0 from then on.
- R5: query_ready is 0 from the acceptance edge until the result is consumed, and busy is 1 exactly when query_ready is 0.
- R6: When NUM_ROWS is not a multiple of LANES, the unused lanes of the final batch take no part in the comparison. The reported row is always below NUM_ROWS, and rows in the final partial batch can win.
- R7: After reset every row holds zero, query_ready is 1, busy is 0 and result_valid is 0.
- R8: With wr_en at 1 on an edge, the row named by wr_row takes wr_hash, and a later write to the same row replaces it.
- R9: top1_score is $clog2(HASH_W+1) bits wide, so that a full-width score fits (10 bits for the default 512-bit hash).
- R10: result_valid rises after exactly ceil(NUM_ROWS/LANES) clock edges following the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store wr_hash into row wr_row on this edge |
| wr_row | input | ROW_W | Row number to write |
| wr_hash | input | HASH_W | Hash to store |
| query_valid | input | 1 | Query hash offered |
| query_ready | output | 1 | Engine idle and able to accept a query |
| query_hash | input | HASH_W | Query hash |
| result_valid | output | 1 | Winner available |
| result_ready | input | 1 | Consumer takes the winner |
| top1_row | output | ROW_W | Index of the best-matching row |
| top1_score | output | SCORE_W | Number of agreeing bits of that row |
| busy | output | 1 | Scan in progress or result pending |

## Verification
The bench uses a geometry of 22 rows and 4 lanes, so the last batch is half empty. It then places a unique full-score match in row 21. A design that lets a phantom lane compete, or that drops the last batch, would report the wrong row or an index past the table. Identical copies of the query are planted at several rows, and a table of uniform rows is also used. A design that replaces the winner on equal scores, or compares lanes in the wrong order, would return a higher index than row 3 or row 0. The query bus is scrambled after acceptance to expose a design that does not latch the query hash. The result is also held against a stalled consumer to expose a design that drops or changes the result before it is consumed.

// File: rtl/ham_pkg.sv
package ham_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_RESULT = 2'd2
    } ham_state_e;

endpackage

// File: rtl/ham_row_store.sv
module ham_row_store #(
    parameter int NUM_ROWS = 512,
    parameter int HASH_W   = 512,
    parameter int LANES    = 4,
    parameter int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ROW_W-1:0]          wr_row,
    input  logic [HASH_W-1:0]         wr_hash,
    input  logic [LANES*ROW_W-1:0]    rd_addr_flat,
    output logic [LANES*HASH_W-1:0]   rd_hash_flat
);

    logic [HASH_W-1:0] rows_q [NUM_ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_ROWS; r++) begin
                rows_q[r] <= '0;
            end
        end else if (wr_en && (32'(wr_row) < 32'(NUM_ROWS))) begin
            rows_q[wr_row] <= wr_hash;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        logic [ROW_W-1:0] addr;
        assign addr = rd_addr_flat[l*ROW_W +: ROW_W];
        assign rd_hash_flat[l*HASH_W +: HASH_W] =
            (32'(addr) < 32'(NUM_ROWS)) ? rows_q[addr] : '0;
    end

    // R8: an accepted write is visible in the addressed row on the next cycle
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_row) < 32'(NUM_ROWS)))
        |=> (rows_q[$past(wr_row)] == $past(wr_hash)));

endmodule

// File: rtl/ham_lane_score.sv
module ham_lane_score #(
    parameter int HASH_W  = 512,
    parameter int SCORE_W = $clog2(HASH_W + 1)
) (
    input  logic [HASH_W-1:0]  query,
    input  logic [HASH_W-1:0]  row_hash,
    output logic [SCORE_W-1:0] score
);

    logic [HASH_W-1:0] agree;

    assign agree = ~(query ^ row_hash);

    always_comb begin
        score = '0;
        for (int i = 0; i < HASH_W; i++) begin
            score = score + SCORE_W'(agree[i]);
        end
    end

endmodule

// File: rtl/ham_best_pick.sv
module ham_best_pick #(
    parameter int LANES   = 4,
    parameter int ROW_W   = 9,
    parameter int SCORE_W = 10
) (
    input  logic                     in_vld,
    input  logic [SCORE_W-1:0]       in_score,
    input  logic [ROW_W-1:0]         in_row,
    input  logic [LANES-1:0]         lane_vld,
    input  logic [LANES*SCORE_W-1:0] lane_score_flat,
    input  logic [LANES*ROW_W-1:0]   lane_row_flat,
    output logic                     out_vld,
    output logic [SCORE_W-1:0]       out_score,
    output logic [ROW_W-1:0]         out_row
);

    // Lanes are folded in ascending row order; a candidate replaces the
    // running winner only on a strictly greater score (or when none is held).
    always_comb begin
        out_vld   = in_vld;
        out_score = in_score;
        out_row   = in_row;
        for (int l = 0; l < LANES; l++) begin
            if (lane_vld[l] &&
                (!out_vld || (lane_score_flat[l*SCORE_W +: SCORE_W] > out_score))) begin
                out_vld   = 1'b1;
                out_score = lane_score_flat[l*SCORE_W +: SCORE_W];
                out_row   = lane_row_flat[l*ROW_W +: ROW_W];
            end
        end
    end

endmodule

// File: rtl/ham_top1_search.sv
module ham_top1_search #(
    parameter int NUM_ROWS = 512,
    parameter int HASH_W   = 512,
    parameter int LANES    = 4,
    parameter int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    parameter int SCORE_W  = $clog2(HASH_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ROW_W-1:0]   wr_row,
    input  logic [HASH_W-1:0]  wr_hash,
    input  logic               query_valid,
    output logic               query_ready,
    input  logic [HASH_W-1:0]  query_hash,
    output logic               result_valid,
    input  logic               result_ready,
    output logic [ROW_W-1:0]   top1_row,
    output logic [SCORE_W-1:0] top1_score,
    output logic               busy
);
    import ham_pkg::*;

    localparam int NUM_BATCH = (NUM_ROWS + LANES - 1) / LANES;
    localparam int BATCH_W   = (NUM_BATCH > 1) ? $clog2(NUM_BATCH) : 1;

    typedef struct packed {
        ham_state_e          state;
        logic [HASH_W-1:0]   query;
        logic [BATCH_W-1:0]  batch;
        logic                best_vld;
        logic [SCORE_W-1:0]  best_score;
        logic [ROW_W-1:0]    best_row;
    } ham_regs_t;

    ham_regs_t cur_q, nxt_d;

    logic [LANES-1:0]         lane_vld;
    logic [LANES*ROW_W-1:0]   lane_row_flat;
    logic [LANES*HASH_W-1:0]  lane_hash_flat;
    logic [LANES*SCORE_W-1:0] lane_score_flat;
    logic                     pick_vld;
    logic [SCORE_W-1:0]       pick_score;
    logic [ROW_W-1:0]         pick_row;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [31:0] idx;
        assign idx         = 32'(cur_q.batch) * 32'(LANES) + 32'(l);
        assign lane_vld[l] = (idx < 32'(NUM_ROWS));
        assign lane_row_flat[l*ROW_W +: ROW_W] = lane_vld[l] ? idx[ROW_W-1:0] : '0;

        ham_lane_score #(
            .HASH_W  (HASH_W),
            .SCORE_W (SCORE_W)
        ) u_score (
            .query    (cur_q.query),
            .row_hash (lane_hash_flat[l*HASH_W +: HASH_W]),
            .score    (lane_score_flat[l*SCORE_W +: SCORE_W])
        );
    end

    ham_row_store #(
        .NUM_ROWS (NUM_ROWS),
        .HASH_W   (HASH_W),
        .LANES    (LANES),
        .ROW_W    (ROW_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_row       (wr_row),
        .wr_hash      (wr_hash),
        .rd_addr_flat (lane_row_flat),
        .rd_hash_flat (lane_hash_flat)
    );

    ham_best_pick #(
        .LANES   (LANES),
        .ROW_W   (ROW_W),
        .SCORE_W (SCORE_W)
    ) u_pick (
        .in_vld          (cur_q.best_vld),
        .in_score        (cur_q.best_score),
        .in_row          (cur_q.best_row),
        .lane_vld        (lane_vld),
        .lane_score_flat (lane_score_flat),
        .lane_row_flat   (lane_row_flat),
        .out_vld         (pick_vld),
        .out_score       (pick_score),
        .out_row         (pick_row)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (query_valid) begin
                    nxt_d.state      = ST_SCAN;
                    nxt_d.query      = query_hash;
                    nxt_d.batch      = '0;
                    nxt_d.best_vld   = 1'b0;
                    nxt_d.best_score = '0;
                    nxt_d.best_row   = '0;
                end
            end
            ST_SCAN: begin
                nxt_d.best_vld   = pick_vld;
                nxt_d.best_score = pick_score;
                nxt_d.best_row   = pick_row;
                if (cur_q.batch == BATCH_W'(NUM_BATCH - 1)) begin
                    nxt_d.state = ST_RESULT;
                end else begin
                    nxt_d.batch = cur_q.batch + 1'b1;
                end
            end
            ST_RESULT: begin
                if (result_ready) begin
                    nxt_d.state = ST_IDLE;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, query: '0, batch: '0, best_vld: 1'b0,
                       best_score: '0, best_row: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign query_ready  = (cur_q.state == ST_IDLE);
    assign result_valid = (cur_q.state == ST_RESULT);
    assign busy         = (cur_q.state != ST_IDLE);
    assign top1_row     = cur_q.best_row;
    assign top1_score   = cur_q.best_score;

    // R4: an unconsumed result stays put
    p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !result_ready)
        |=> (result_valid && $stable(top1_row) && $stable(top1_score)));

    // R5: acceptance closes the query port and raises busy
    p_accept_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (query_valid && query_ready) |=> (!query_ready && busy));

    // R1: a score never exceeds the hash width
    p_score_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (32'(top1_score) <= 32'(HASH_W)));

    // R6: the winner is always a real row
    p_row_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (32'(top1_row) < 32'(NUM_ROWS)));

    // R2: the running best score never decreases within a scan
    p_best_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == ST_SCAN) && cur_q.best_vld)
        |=> (cur_q.best_score >= $past(cur_q.best_score)));

endmodule

// File: tb/ham_top1_search_tb_top.sv
module ham_top1_search_tb_top;

    localparam int NR = 22;
    localparam int HW = 16;
    localparam int LN = 4;
    localparam int RW = $clog2(NR);
    localparam int SW = $clog2(HW + 1);
    localparam int NB = (NR + LN - 1) / LN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [RW-1:0] wr_row = '0;
    logic [HW-1:0] wr_hash = '0;
    logic          query_valid = 1'b0;
    logic          query_ready;
    logic [HW-1:0] query_hash = '0;
    logic          result_valid;
    logic          result_ready = 1'b0;
    logic [RW-1:0] top1_row;
    logic [SW-1:0] top1_score;
    logic          busy;

    logic [HW-1:0] model [NR];
    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    ham_top1_search #(.NUM_ROWS(NR), .HASH_W(HW), .LANES(LN)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_hash(wr_hash),
        .query_valid(query_valid), .query_ready(query_ready), .query_hash(query_hash),
        .result_valid(result_valid), .result_ready(result_ready),
        .top1_row(top1_row), .top1_score(top1_score), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void expect_best(input logic [HW-1:0] q, output int row, output int sc);
        row = -1;
        sc  = -1;
        for (int r = 0; r < NR; r++) begin
            int s;
            s = $countones(~(q ^ model[r]));
            if (s > sc) begin
                sc  = s;
                row = r;
            end
        end
    endfunction

    task automatic write_row(input int r, input logic [HW-1:0] h);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_row  = RW'(r);
        wr_hash = h;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        model[r] = h;
    endtask

    task automatic run_query(input logic [HW-1:0] q, input int hold, input string req);
        int er, es, lat, hr, hs;
        expect_best(q, er, es);
        @(negedge clk);
        while (!query_ready) @(negedge clk);
        query_valid = 1'b1;
        query_hash  = q;
        @(posedge clk);
        @(negedge clk);
        query_valid = 1'b0;
        query_hash  = HW'($urandom);           // R3: scrambled after acceptance
        check(!query_ready && busy, "R5 closed after accept", int'(query_ready), 0);
        lat = 0;
        while (!result_valid && lat < 4 * NB) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        check(lat == NB, "R10 latency", lat, NB);
        check(int'(top1_row) == er, {req, " R1/R2/R3 row"}, int'(top1_row), er);
        check(int'(top1_score) == es, {req, " R1 score"}, int'(top1_score), es);
        hr = int'(top1_row);
        hs = int'(top1_score);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(result_valid && int'(top1_row) == hr && int'(top1_score) == hs,
                  "R4 hold", int'(top1_row), hr);
        end
        result_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        result_ready = 1'b0;
        check(!result_valid && query_ready && !busy, "R4/R5 consumed",
              int'(result_valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int r = 0; r < NR; r++) model[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(query_ready && !busy && !result_valid, "R7 reset state",
              int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(query_ready && !busy && !result_valid, "R7 idle after reset",
              int'(busy), 0);
        check($bits(top1_score) == SW, "R9 score width", $bits(top1_score), SW);

        // R7/R2: all rows zero, every row ties at full score
        run_query('0, 2, "R7 zero table");
        // R2: all tie at zero score
        run_query('1, 0, "R2 all-zero-score tie");

        // Random table, random queries
        for (int r = 0; r < NR; r++) write_row(r, HW'($urandom));
        for (int k = 0; k < 20; k++) begin
            logic [HW-1:0] q;
            if (k % 2 == 0) q = model[$urandom % NR] ^ HW'(1 << ($urandom % HW));
            else q = HW'($urandom);
            run_query(q, k % 3, "random");
        end

        // R2: duplicated exact matches, lowest index wins
        write_row(9, 16'h5A3C);
        write_row(21, 16'h5A3C);
        write_row(3, 16'h5A3C);
        run_query(16'h5A3C, 1, "R2 duplicates");
        check(int'(top1_row) == 3, "R2 lowest index", int'(top1_row), 3);

        // R6: unique winner in the partial final batch
        for (int r = 0; r < NR; r++) write_row(r, '0);
        write_row(21, 16'hFFFF);
        run_query(16'hFFFF, 0, "R6 last batch");
        check(int'(top1_row) == 21 && int'(top1_score) == HW, "R6 row 21 wins",
              int'(top1_row), 21);
        write_row(20, 16'hFFFE);
        run_query(16'hFFFE, 0, "R6 row 20");

        // R8: overwrite row 21, table uniform again -> row 0
        write_row(21, '0);
        write_row(20, '0);
        run_query(16'hFFFF, 1, "R8 overwrite");
        check(int'(top1_row) == 0 && int'(top1_score) == 0, "R8 overwritten row gone",
              int'(top1_row), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule